// File: doc/BRIEF.md
# Reset Sequencing Controller

This block merges every reset request a small microcontroller core can raise into one chip-wide reset. It holds that reset until two start-up delays have run one after the other. The first delay counts ticks of a slow internal time base and lets the supply settle. The second counts main-clock cycles and lets the oscillator settle. The block also keeps a small vector of cause flags. After a reset, software reads these flags to learn which kind of event caused it.

Eight kinds of reset are recognised:

- power-on, through the asynchronous `por_n` input;
- the external reset pin while the core runs;
- the external reset pin while the core sleeps or idles;
- watchdog expiry;
- brown-out;
- a reset instruction;
- return-stack overflow;
- return-stack underflow.

The pin is input only, and nothing inside the block drives it. A majority-free run-length filter screens the pin for glitches, and a configuration bit can switch the pin off entirely. A second enable bit gates brown-out detection.

All inputs except `por_n` and `ext_rst_n` are synchronous to `clk`. `slow_tick` is a one-cycle enable that marks each period of the slow time base.

Top module: `rst_seq_ctrl`

## Requirements
- R1: While `por_n` is low, `chip_rst` is 1 and `cause` is 5'b11100. Cause bit positions are: [4] instruction flag, [3] watchdog flag, [2] sleep flag, [1] power flag, [0] brown-out flag. The block leaves reset two `clk` edges after `por_n` rises.
- R2: Once no request is active, `chip_rst` stays 1 while `PWRT_TICKS` accepted `slow_tick` pulses are counted. It then stays 1 for exactly `OST_CYCLES` more `clk` edges and falls after the last of them.
- R3: A request that arrives while the delays are running restarts both delays from zero, and `chip_rst` never drops in between.
- R4: The pin (active low) causes a reset only after it has been seen low on `FILT_LEN` consecutive `slow_tick` samples (default 4); shorter pulses cause nothing.
- R5: With `ext_en` at 0, pin activity causes no reset.
- R6: `bor_det` causes a reset and clears cause bit [0] only when `bor_en` is 1.
- R7: A `sw_reset` pulse causes a reset and clears cause bit [4].
- R8: A `wdt_timeout` pulse causes a reset and clears cause bit [3].
- R9: A pin reset taken while `in_sleep` is 1 clears cause bit [2]. A pin reset taken while running leaves all flags unchanged.
- R10: `stk_full` and `stk_unf` each cause a reset and leave all flags unchanged.
- R11: A 1 on `flag_set[i]` sets cause bit i. When a set and a clear hit the same bit in the same cycle, the clear wins.
- R12: With no request and no `flag_set`, `chip_rst` stays 0 after release, and `cause` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | main oscillator clock |
| por_n | input | 1 | asynchronous power-on reset, active low |
| slow_tick | input | 1 | one-cycle enable per slow time-base period |
| ext_rst_n | input | 1 | external reset pin, active low, asynchronous |
| ext_en | input | 1 | enables the external pin as a reset source |
| in_sleep | input | 1 | core is in sleep or idle |
| wdt_timeout | input | 1 | watchdog expiry strobe |
| bor_det | input | 1 | brown-out detected (level) |
| bor_en | input | 1 | enables brown-out as a reset source |
| sw_reset | input | 1 | reset instruction strobe |
| stk_full | input | 1 | return-stack overflow strobe |
| stk_unf | input | 1 | return-stack underflow strobe |
| flag_set | input | 5 | software set strobes for the cause flags |
| chip_rst | output | 1 | chip reset, active high |
| cause | output | 5 | cause flags, bit map as in R1 |

## Verification
Flag changes and `chip_rst` assertion appear one `clk` edge after the request cycle, so the bench samples them at the falling edge after that edge. Release timing is measured from the falling edge where the last request is withdrawn. The bench counts the `slow_tick` values that the design will see at the following rising edges. After the `PWRT_TICKS`-th tick, it expects `chip_rst` still high after `OST_CYCLES`-1 further edges and low after one more.

The pin path has a synchronizer and a tick-sampled filter, so its onset and end are not cycle-exact. Pin cases are therefore checked by level after generous margins, and release is checked with a bounded wait.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;

  typedef enum logic [1:0] {
    PH_PWRT = 2'd0,
    PH_OST  = 2'd1,
    PH_RUN  = 2'd2
  } rst_phase_e;

  localparam int FLG_W   = 5;
  localparam int FLG_BRN = 0;
  localparam int FLG_PWR = 1;
  localparam int FLG_SLP = 2;
  localparam int FLG_WDT = 3;
  localparam int FLG_INS = 4;

  localparam logic [FLG_W-1:0] FLG_POWERON = 5'b11100;

endpackage

// File: rtl/rst_pin_filter.sv
module rst_pin_filter #(
  parameter int FILT_LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic pin_n,
  output logic hit
);

  localparam int CW = $clog2(FILT_LEN + 1);

  logic [1:0]    sync_q;
  logic [CW-1:0] cnt_q, cnt_d;

  // run-length of low samples, saturating at FILT_LEN
  always_comb begin
    cnt_d = cnt_q;
    if (tick) begin
      if (sync_q[1])
        cnt_d = '0;
      else if (cnt_q != CW'(FILT_LEN))
        cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b11;
      cnt_q  <= '0;
    end else begin
      sync_q <= {sync_q[0], pin_n};
      cnt_q  <= cnt_d;
    end
  end

  assign hit = (cnt_q == CW'(FILT_LEN));

endmodule

// File: rtl/rst_delay_chain.sv
module rst_delay_chain
  import rst_seq_pkg::*;
#(
  parameter int PWRT_TICKS = 2048,
  parameter int OST_CYCLES = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic req,
  output logic hold
);

  localparam int MAXN = (PWRT_TICKS > OST_CYCLES) ? PWRT_TICKS : OST_CYCLES;
  localparam int CW   = $clog2(MAXN + 1);

  rst_phase_e    ph_q, ph_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    ph_d  = ph_q;
    cnt_d = cnt_q;
    if (req) begin
      ph_d  = PH_PWRT;
      cnt_d = '0;
    end else begin
      case (ph_q)
        PH_PWRT: begin
          if (tick) begin
            if (cnt_q == CW'(PWRT_TICKS - 1)) begin
              ph_d  = PH_OST;
              cnt_d = '0;
            end else begin
              cnt_d = cnt_q + 1'b1;
            end
          end
        end
        PH_OST: begin
          if (cnt_q == CW'(OST_CYCLES - 1)) begin
            ph_d  = PH_RUN;
            cnt_d = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_PWRT;
      cnt_q <= '0;
    end else begin
      ph_q  <= ph_d;
      cnt_q <= cnt_d;
    end
  end

  assign hold = (ph_q != PH_RUN);

endmodule

// File: rtl/rst_cause_flags.sv
module rst_cause_flags
  import rst_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [FLG_W-1:0] clr,
  input  logic [FLG_W-1:0] set,
  output logic [FLG_W-1:0] flags
);

  logic [FLG_W-1:0] flags_q, flags_d;

  // clear beats set
  always_comb flags_d = (flags_q | set) & ~clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= FLG_POWERON;
    else        flags_q <= flags_d;
  end

  assign flags = flags_q;

endmodule

// File: rtl/rst_seq_ctrl.sv
module rst_seq_ctrl
  import rst_seq_pkg::*;
#(
  parameter int PWRT_TICKS = 2048,
  parameter int OST_CYCLES = 1024,
  parameter int FILT_LEN   = 4
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             slow_tick,
  input  logic             ext_rst_n,
  input  logic             ext_en,
  input  logic             in_sleep,
  input  logic             wdt_timeout,
  input  logic             bor_det,
  input  logic             bor_en,
  input  logic             sw_reset,
  input  logic             stk_full,
  input  logic             stk_unf,
  input  logic [FLG_W-1:0] flag_set,
  output logic             chip_rst,
  output logic [FLG_W-1:0] cause
);

  logic [1:0]       por_sync_q;
  logic             rst_sync_n;
  logic             pin_hit, pin_req, bor_req, req_any;
  logic [FLG_W-1:0] flg_clr;

  // power-on: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) por_sync_q <= 2'b00;
    else        por_sync_q <= {por_sync_q[0], 1'b1};
  end
  assign rst_sync_n = por_sync_q[1];

  rst_pin_filter #(.FILT_LEN(FILT_LEN)) u_filt (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .tick  (slow_tick),
    .pin_n (ext_rst_n),
    .hit   (pin_hit)
  );

  assign pin_req = ext_en & pin_hit;
  assign bor_req = bor_det & bor_en;
  assign req_any = pin_req | bor_req | wdt_timeout | sw_reset | stk_full | stk_unf;

  always_comb begin
    flg_clr          = '0;
    flg_clr[FLG_INS] = sw_reset;
    flg_clr[FLG_WDT] = wdt_timeout;
    flg_clr[FLG_SLP] = pin_req & in_sleep;
    flg_clr[FLG_BRN] = bor_req;
  end

  rst_delay_chain #(.PWRT_TICKS(PWRT_TICKS), .OST_CYCLES(OST_CYCLES)) u_chain (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .tick  (slow_tick),
    .req   (req_any),
    .hold  (chip_rst)
  );

  rst_cause_flags u_flags (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .clr   (flg_clr),
    .set   (flag_set),
    .flags (cause)
  );

endmodule

// File: rtl/rst_seq_chk.sv
module rst_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ext_en,
  input logic       wdt_timeout,
  input logic       bor_det,
  input logic       bor_en,
  input logic       sw_reset,
  input logic       stk_full,
  input logic       stk_unf,
  input logic [4:0] flag_set,
  input logic       chip_rst,
  input logic [4:0] cause
);

  logic strobe_any;
  assign strobe_any = wdt_timeout | sw_reset | stk_full | stk_unf | (bor_det & bor_en);

  p_req_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_any |=> chip_rst);

  p_release_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(chip_rst) |-> !$past(strobe_any));

  p_instr_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sw_reset |=> !cause[4]);

  p_wdt_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_timeout |=> !cause[3]);

  p_bor_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bor_det && bor_en) |=> !cause[0]);

  // R5 and R6: gated sources cannot start a reset
  p_gated_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!chip_rst && !ext_en && !strobe_any) |=> !chip_rst);

  p_flag_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe_any && !ext_en && flag_set == 5'd0) |=> $stable(cause));

  p_pwr_flag_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_set[1] |=> $stable(cause[1]));

endmodule

bind rst_seq_ctrl rst_seq_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .ext_en      (ext_en),
  .wdt_timeout (wdt_timeout),
  .bor_det     (bor_det),
  .bor_en      (bor_en),
  .sw_reset    (sw_reset),
  .stk_full    (stk_full),
  .stk_unf     (stk_unf),
  .flag_set    (flag_set),
  .chip_rst    (chip_rst),
  .cause       (cause)
);

// File: tb/rst_seq_ctrl_tb.sv
`timescale 1ns/1ps
module rst_seq_ctrl_tb;

  localparam int P  = 16;
  localparam int OC = 32;
  localparam int FL = 4;

  localparam int SRC_WDT = 0;
  localparam int SRC_SW  = 1;
  localparam int SRC_SF  = 2;
  localparam int SRC_SU  = 3;
  localparam int SRC_BOR = 4;

  logic       clk = 1'b0;
  logic       por_n, ext_rst_n, ext_en, in_sleep;
  logic       wdt_timeout, bor_det, bor_en, sw_reset, stk_full, stk_unf;
  logic [4:0] flag_set;
  logic       chip_rst;
  logic [4:0] cause;
  logic [1:0] div = 2'd0;
  logic       slow_tick = 1'b0;

  int         n_chk = 0;
  int         n_bad = 0;
  logic [4:0] exp_f;

  always #4 clk = ~clk;

  always @(posedge clk) begin
    div       <= div + 2'd1;
    slow_tick <= (div == 2'd3);
  end

  rst_seq_ctrl #(.PWRT_TICKS(P), .OST_CYCLES(OC), .FILT_LEN(FL)) u_dut (
    .clk(clk), .por_n(por_n), .slow_tick(slow_tick), .ext_rst_n(ext_rst_n),
    .ext_en(ext_en), .in_sleep(in_sleep), .wdt_timeout(wdt_timeout),
    .bor_det(bor_det), .bor_en(bor_en), .sw_reset(sw_reset),
    .stk_full(stk_full), .stk_unf(stk_unf), .flag_set(flag_set),
    .chip_rst(chip_rst), .cause(cause)
  );

  task automatic check_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [4:0] model(input logic [4:0] f, input int src,
                                       input bit bor_on, input logic [4:0] fs);
    logic [4:0] r;
    r = f | fs;
    case (src)
      SRC_WDT: r[3] = 1'b0;
      SRC_SW:  r[4] = 1'b0;
      SRC_BOR: if (bor_on) r[0] = 1'b0;
      default: ;
    endcase
    return r;
  endfunction

  task automatic pulse(input int src, input int width, input logic [4:0] fs);
    @(negedge clk);
    case (src)
      SRC_WDT: wdt_timeout = 1'b1;
      SRC_SW:  sw_reset    = 1'b1;
      SRC_SF:  stk_full    = 1'b1;
      SRC_SU:  stk_unf     = 1'b1;
      SRC_BOR: bor_det     = 1'b1;
      default: ;
    endcase
    flag_set = fs;
    repeat (width) @(negedge clk);
    wdt_timeout = 1'b0; sw_reset = 1'b0; stk_full = 1'b0;
    stk_unf = 1'b0; bor_det = 1'b0; flag_set = 5'd0;
  endtask

  // exact release timing, counted from the current falling edge (R2)
  task automatic wait_release(input int skip, input string tag);
    int seen;
    bit held;
    seen = 0;
    held = 1'b1;
    repeat (skip) @(negedge clk);
    while (1) begin
      if (!chip_rst) held = 1'b0;
      if (slow_tick) seen++;
      if (seen == P) break;
      @(negedge clk);
    end
    check_eq({tag, " R2 held through tick delay"}, 32'(held), 32'd1);
    repeat (OC) @(negedge clk);
    check_eq({tag, " R2 still held at last cycle"}, 32'(chip_rst), 32'd1);
    @(negedge clk);
    check_eq({tag, " R2 released"}, 32'(chip_rst), 32'd0);
  endtask

  task automatic wait_loose(input string tag);
    int n;
    n = 0;
    while (chip_rst && n < (P * 4 + OC + 200)) begin
      @(negedge clk);
      n++;
    end
    check_eq({tag, " released"}, 32'(chip_rst), 32'd0);
  endtask

  task automatic watch_quiet(input int cycles, input string tag);
    bit quiet;
    quiet = 1'b1;
    repeat (cycles) begin
      @(negedge clk);
      if (chip_rst) quiet = 1'b0;
    end
    check_eq(tag, 32'(quiet), 32'd1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    por_n = 1'b0; ext_rst_n = 1'b1; ext_en = 1'b1; in_sleep = 1'b0;
    wdt_timeout = 1'b0; bor_det = 1'b0; bor_en = 1'b0; sw_reset = 1'b0;
    stk_full = 1'b0; stk_unf = 1'b0; flag_set = 5'd0;
    repeat (5) @(negedge clk);
    check_eq("R1 reset held", 32'(chip_rst), 32'd1);
    check_eq("R1 power-on flags", 32'(cause), 32'h1C);
    exp_f = 5'b11100;
    por_n = 1'b1;
    wait_release(2, "R1 power-on");
    check_eq("R1 flags after release", 32'(cause), 32'(exp_f));

    // R7 + R11: reset instruction with a same-cycle set of its own bit
    pulse(SRC_SW, 1, 5'b10000);
    exp_f = model(exp_f, SRC_SW, 1'b0, 5'b10000);
    wait_release(0, "R7");
    check_eq("R7 R11 clear beats set", 32'(cause), 32'(exp_f));

    // R11: software set of all flags, no reset
    @(negedge clk); flag_set = 5'b11111;
    @(negedge clk); flag_set = 5'd0;
    exp_f = 5'b11111;
    check_eq("R11 set all", 32'(cause), 32'(exp_f));
    check_eq("R11 no reset", 32'(chip_rst), 32'd0);

    // R8 watchdog
    pulse(SRC_WDT, 1, 5'd0);
    exp_f = model(exp_f, SRC_WDT, 1'b0, 5'd0);
    wait_release(0, "R8");
    check_eq("R8 watchdog flag", 32'(cause), 32'(exp_f));

    // R3 restart mid-chain, then R10 flags untouched
    begin
      int t;
      bit held;
      pulse(SRC_WDT, 1, 5'd0);
      exp_f = model(exp_f, SRC_WDT, 1'b0, 5'd0);
      t = 0; held = 1'b1;
      while (t < P / 2) begin
        @(negedge clk);
        if (!chip_rst) held = 1'b0;
        if (slow_tick) t++;
      end
      check_eq("R3 held before restart", 32'(held), 32'd1);
      pulse(SRC_SF, 1, 5'd0);
      wait_release(0, "R3 restart");
      check_eq("R10 stack full flags", 32'(cause), 32'(exp_f));
    end

    pulse(SRC_SU, 2, 5'd0);
    wait_release(0, "R10 underflow");
    check_eq("R10 underflow flags", 32'(cause), 32'(exp_f));

    // R6 gated brown-out
    bor_en = 1'b0;
    @(negedge clk); bor_det = 1'b1;
    watch_quiet(40, "R6 disabled brown-out no reset");
    bor_det = 1'b0;
    check_eq("R6 disabled flags", 32'(cause), 32'(exp_f));
    bor_en = 1'b1;
    pulse(SRC_BOR, 3, 5'd0);
    exp_f = model(exp_f, SRC_BOR, 1'b1, 5'd0);
    wait_release(0, "R6");
    check_eq("R6 brown-out flag", 32'(cause), 32'(exp_f));
    bor_en = 1'b0;

    // R4 short pin pulse filtered
    @(negedge clk); ext_rst_n = 1'b0;
    repeat (8) @(negedge clk);
    ext_rst_n = 1'b1;
    watch_quiet(40, "R4 short pulse no reset");

    // R5 disabled pin
    ext_en = 1'b0;
    @(negedge clk); ext_rst_n = 1'b0;
    watch_quiet(60, "R5 disabled pin no reset");
    ext_rst_n = 1'b1;
    repeat (12) @(negedge clk);
    ext_en = 1'b1;
    check_eq("R5 flags", 32'(cause), 32'(exp_f));

    // R4 + R9 long pin while running
    @(negedge clk); ext_rst_n = 1'b0;
    repeat (60) @(negedge clk);
    check_eq("R4 long pulse resets", 32'(chip_rst), 32'd1);
    ext_rst_n = 1'b1;
    wait_loose("R4 pin");
    check_eq("R9 running pin flags", 32'(cause), 32'(exp_f));

    // R9 pin while sleeping
    in_sleep = 1'b1;
    @(negedge clk); ext_rst_n = 1'b0;
    repeat (60) @(negedge clk);
    ext_rst_n = 1'b1;
    wait_loose("R9 sleep pin");
    in_sleep = 1'b0;
    exp_f[2] = 1'b0;
    check_eq("R9 sleep flag", 32'(cause), 32'(exp_f));

    // random mix
    for (int i = 0; i < 40; i++) begin
      int src;
      int w;
      logic [4:0] fs;
      src = $urandom_range(0, 5);
      w   = $urandom_range(1, 3);
      fs  = ($urandom_range(0, 3) == 0) ? 5'($urandom()) : 5'd0;
      if (src == 5) begin
        @(negedge clk); flag_set = fs;
        @(negedge clk); flag_set = 5'd0;
        exp_f = exp_f | fs;
        check_eq("R11 random set", 32'(cause), 32'(exp_f));
        check_eq("R12 random no reset", 32'(chip_rst), 32'd0);
      end else if (src == SRC_BOR && $urandom_range(0, 1) == 0) begin
        bor_en = 1'b0;
        pulse(SRC_BOR, w, fs);
        exp_f = model(exp_f, SRC_BOR, 1'b0, fs);
        watch_quiet(4, "R6 random gated");
        check_eq("R6 random gated flags", 32'(cause), 32'(exp_f));
      end else begin
        bor_en = (src == SRC_BOR);
        pulse(src, w, fs);
        exp_f = model(exp_f, src, bor_en, fs);
        if ($urandom_range(0, 3) == 0) begin
          repeat ($urandom_range(5, 60)) @(negedge clk);
          pulse(SRC_SF, 1, 5'd0);
          wait_release(0, "R3 random restart");
        end else begin
          wait_release(0, "R2 random");
        end
        check_eq("R10 random flags", 32'(cause), 32'(exp_f));
        bor_en = 1'b0;
      end
    end

    // R12 idle
    watch_quiet(100, "R12 idle no reset");
    check_eq("R12 idle flags", 32'(cause), 32'(exp_f));

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule